// File: doc/BRIEF.md
# Memory-Mapped External I/O Unit

This unit connects the load/store path of a small 16-bit processor to its 512-word data RAM and to one external input channel and one external output channel. No separate I/O opcodes are needed: two ordinary memory operations are given a second meaning. A store whose register field is register zero sends a RAM word out. A load whose address has the otherwise unused bit 9 set brings an external word into RAM.

An output copies the RAM word at the given address into an output buffer and raises an output-ready flag. The flag stays up until the external side acknowledges it. An input idle-waits: the unit holds the pipeline stalled until the external side flags its data ready, then writes that word into RAM. All other loads and stores are plain synchronous RAM accesses. The RAM is an internal synchronous array whose contents survive reset.

Top module: `ext_io_unit`

## Requirements
- R1: A store (`req_write`=1) with `req_reg` not zero writes `req_wdata` to RAM word `req_addr[8:0]` at the edge of the request cycle. A load in the next cycle returns the new value, and `rd_valid` is low in the cycle after a store.
- R2: A load (`req_write`=0) with `req_addr[9]`=0 that is not stalled drives `rd_data` with RAM word `req_addr[8:0]` and `rd_valid`=1 exactly one cycle later. `rd_valid` is 0 after any cycle without such a load.
- R3: A store with `req_reg`=0 while `ext_out_ready` is low makes, one cycle later, `ext_out_data` equal to RAM word `req_addr[8:0]` and `ext_out_ready`=1. It does not write RAM, so `req_wdata` is ignored.
- R4: `ext_out_ready` stays high, with `ext_out_data` unchanged, until a cycle in which `ext_out_ack` is high. It is low in the cycle after that acknowledge.
- R5: An output store issued while `ext_out_ready` is high raises `stall` in that same cycle and leaves the buffer unchanged. Once the flag has been cleared, the held request completes as in R3.
- R6: A load with `req_addr[9]`=1 raises `stall` from its issue cycle up to and including the first cycle in which `ext_in_ready` is high. `ext_in_data` is written to RAM word `req_addr[8:0]` at that edge, and `stall` is low in the following cycle if no new stalling request is present.
- R7: `ext_in_ready` and `ext_in_data` have no effect on RAM while no external input is pending.
- R8: A synchronous active-low `rst_n` clears `ext_out_data`, `ext_out_ready`, `rd_valid` and any pending input wait. RAM contents are kept.
- R9: For stores, `req_addr[9]` is ignored: a store to an address with bit 9 set writes word `req_addr[8:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Memory request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_reg | input | 4 | Register field of the store (0 selects external output) |
| req_addr | input | 10 | Word address; bit 9 on a load selects external input |
| req_wdata | input | 16 | Store data |
| rd_data | output | 16 | Load result, one cycle after the request |
| rd_valid | output | 1 | `rd_data` holds a load result |
| stall | output | 1 | Pipeline must hold its current request |
| ext_in_data | input | 16 | External input word |
| ext_in_ready | input | 1 | External input word is available |
| ext_out_data | output | 16 | Output buffer contents |
| ext_out_ready | output | 1 | Output buffer holds an unacknowledged word |
| ext_out_ack | input | 1 | External side has taken the output word |

## Verification
A wrong pending-input state shows at once on `stall`: it either stays high after the ready cycle or drops while the external side is still silent. A corrupt RAM write shows on the next normal load of that word. A lost or early-cleared output flag shows on `ext_out_ready` in the cycle after the faulty edge. A buffer overwrite while the flag is up shows on `ext_out_data` in the next cycle. For this reason the bench compares the outputs every cycle against expectations that are due on specific cycles, and it reads back RAM through loads after every input and reset.

// File: rtl/ext_io_unit.sv
module ext_io_unit #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 9,
  parameter int REG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [ADDR_W:0]   req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              stall,
  input  logic [DATA_W-1:0] ext_in_data,
  input  logic              ext_in_ready,
  output logic [DATA_W-1:0] ext_out_data,
  output logic              ext_out_ready,
  input  logic              ext_out_ack
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              in_wait_q;
  logic [ADDR_W-1:0] in_addr_q;

  wire [ADDR_W-1:0] word   = req_addr[ADDR_W-1:0];
  wire              go     = req_valid & ~in_wait_q;
  wire              is_in  = ~req_write & req_addr[ADDR_W];
  wire              is_out = req_write & (req_reg == '0);
  wire              st_ok  = go & req_write & ~is_out;
  wire              ld_ok  = go & ~req_write & ~req_addr[ADDR_W];
  wire              in_now = go & is_in;
  wire              out_ok = go & is_out & ~ext_out_ready;

  assign stall = in_wait_q | (req_valid & (is_in | (is_out & ext_out_ready)));

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = word;
    wr_data = req_wdata;
    if (in_wait_q && ext_in_ready) begin
      wr_en   = 1'b1;
      wr_addr = in_addr_q;
      wr_data = ext_in_data;
    end else if (in_now && ext_in_ready) begin
      wr_en   = 1'b1;
      wr_data = ext_in_data;
    end else if (st_ok) begin
      wr_en   = 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_wait_q <= 1'b0;
      in_addr_q <= '0;
    end else if (in_wait_q) begin
      if (ext_in_ready) in_wait_q <= 1'b0;
    end else if (in_now && !ext_in_ready) begin
      in_wait_q <= 1'b1;
      in_addr_q <= word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= ld_ok;
      if (ld_ok) rd_data <= mem[word];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_out_data  <= '0;
      ext_out_ready <= 1'b0;
    end else if (out_ok) begin
      ext_out_data  <= mem[word];
      ext_out_ready <= 1'b1;
    end else if (ext_out_ack) begin
      ext_out_ready <= 1'b0;
    end
  end

  // R2
  load_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !stall && !req_write && !req_addr[ADDR_W]) |=> rd_valid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !stall && !req_write && !req_addr[ADDR_W]) |=> !rd_valid);
  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_out_ready && !ext_out_ack) |=> (ext_out_ready && $stable(ext_out_data)));
  // R4
  out_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_out_ready && ext_out_ack) |=> !ext_out_ready);
  // R5
  out_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_reg == '0 && ext_out_ready) |-> stall);
  // R6
  in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait_q && !ext_in_ready) |=> (in_wait_q && stall));
  // R6
  in_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait_q && ext_in_ready) |=> !in_wait_q);
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!ext_out_ready && !rd_valid && !in_wait_q && ext_out_data == '0));
endmodule

// File: tb/tb_ext_io_unit.sv
module tb_ext_io_unit;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [3:0] req_reg = 0;
  logic [9:0] req_addr = 0;
  logic [15:0] req_wdata = 0, ext_in_data = 0;
  logic ext_in_ready = 0, ext_out_ack = 0;
  logic [15:0] rd_data, ext_out_data;
  logic rd_valid, stall, ext_out_ready;

  ext_io_unit dut (.clk, .rst_n, .req_valid, .req_write, .req_reg, .req_addr,
    .req_wdata, .rd_data, .rd_valid, .stall, .ext_in_data, .ext_in_ready,
    .ext_out_data, .ext_out_ready, .ext_out_ack);

  always #(CLK_P/2) clk = ~clk;

  typedef struct { int due; int kind; logic [15:0] val; string req; } exp_t;
  exp_t q[$];
  logic [15:0] mdl [512];
  int cyc = 0, vecs = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  task automatic push(int kind, logic [15:0] val, string r);
    exp_t e;
    e.due = cyc + 1; e.kind = kind; e.val = val; e.req = r;
    q.push_back(e);
  endtask

  // monitor: kinds 0 rd_data, 1 rd_valid, 2 ext_out_data, 3 ext_out_ready
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        case (q[i].kind)
          0: begin chk(q[i].req, rd_data, q[i].val); chk(q[i].req, {15'b0, rd_valid}, 16'd1); end
          1: chk(q[i].req, {15'b0, rd_valid}, q[i].val);
          2: chk(q[i].req, ext_out_data, q[i].val);
          default: chk(q[i].req, {15'b0, ext_out_ready}, q[i].val);
        endcase
        q.delete(i);
      end
    end
  end

  task automatic idle();
    req_valid = 0;
    @(negedge clk);
  endtask

  task automatic st(logic [9:0] a, logic [15:0] d, logic [3:0] r, string tag);
    req_valid = 1; req_write = 1; req_reg = r; req_addr = a; req_wdata = d;
    #1 chk({tag, " store no stall"}, {15'b0, stall}, 16'd0);
    push(1, 16'd0, {tag, " rd_valid low after store"});
    mdl[a[8:0]] = d;
    @(negedge clk);
  endtask

  task automatic ld(logic [9:0] a, string tag);
    req_valid = 1; req_write = 0; req_reg = 0; req_addr = a;
    #1 chk({tag, " load no stall"}, {15'b0, stall}, 16'd0);
    push(0, mdl[a[8:0]], {tag, " load data"});
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mdl[i] = 16'hx;
    ext_in_ready = 1; ext_in_data = 16'h7777;
    repeat (3) @(negedge clk);
    chk("R8 reset out ready", {15'b0, ext_out_ready}, 16'd0);
    chk("R8 reset rd_valid", {15'b0, rd_valid}, 16'd0);
    chk("R8 reset stall", {15'b0, stall}, 16'd0);
    chk("R8 reset out data", ext_out_data, 16'd0);
    ext_in_ready = 0;
    rst_n = 1;
    @(negedge clk);

    // R1 normal stores, several registers and data patterns
    st(10'd3, 16'h1234, 4'd1, "R1");
    st(10'd5, 16'hA5A5, 4'd7, "R1");
    st(10'd511, 16'hFFFF, 4'd15, "R1");
    st(10'd0, 16'h0001, 4'd2, "R1");
    // R9 bit 9 ignored by stores
    st(10'h207, 16'h4242, 4'd3, "R9");
    // R2 loads read back
    ld(10'd3, "R2");
    ld(10'd511, "R2");
    ld(10'd7, "R9");
    ld(10'd0, "R1");
    idle();
    chk("R2 rd_valid low when idle", {15'b0, rd_valid}, 16'd0);

    // R3 external output, req_wdata ignored
    req_valid = 1; req_write = 1; req_reg = 0; req_addr = 10'd5; req_wdata = 16'hDEAD;
    #1 chk("R3 output no stall", {15'b0, stall}, 16'd0);
    push(2, mdl[5], "R3 out data");
    push(3, 16'd1, "R3 out ready");
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 3; i++) begin
      push(2, mdl[5], "R4 out data held");
      push(3, 16'd1, "R4 out ready held");
      @(negedge clk);
    end
    ld(10'd5, "R3 ram unchanged");

    // R5 second output blocked while ready high
    req_valid = 1; req_write = 1; req_reg = 0; req_addr = 10'd3; req_wdata = 16'h0BAD;
    for (int i = 0; i < 2; i++) begin
      #1 chk("R5 blocked output stalls", {15'b0, stall}, 16'd1);
      push(2, mdl[5], "R5 buffer unchanged");
      @(negedge clk);
    end
    ext_out_ack = 1;
    #1 chk("R5 stall during ack", {15'b0, stall}, 16'd1);
    push(3, 16'd0, "R4 ready cleared by ack");
    @(negedge clk);
    ext_out_ack = 0;
    #1 chk("R5 stall released", {15'b0, stall}, 16'd0);
    push(2, mdl[3], "R5 held output completes");
    push(3, 16'd1, "R5 ready again");
    @(negedge clk);
    req_valid = 0; ext_out_ack = 1;
    push(3, 16'd0, "R4 ready cleared");
    @(negedge clk);
    ext_out_ack = 0;

    // R6 external input with waiting
    req_valid = 1; req_write = 0; req_reg = 0; req_addr = 10'h200 | 10'd9;
    ext_in_data = 16'hBEEF; ext_in_ready = 0;
    for (int i = 0; i < 3; i++) begin
      #1 chk("R6 stall while waiting", {15'b0, stall}, 16'd1);
      push(1, 16'd0, "R6 no rd_valid for input");
      @(negedge clk);
    end
    ext_in_ready = 1;
    #1 chk("R6 stall in ready cycle", {15'b0, stall}, 16'd1);
    @(negedge clk);
    req_valid = 0; ext_in_ready = 0; ext_in_data = 16'h0;
    #1 chk("R6 stall drops", {15'b0, stall}, 16'd0);
    mdl[9] = 16'hBEEF;
    @(negedge clk);
    ld(10'd9, "R6 input written");

    // R6 ready already high at issue
    req_valid = 1; req_write = 0; req_addr = 10'h200 | 10'd11;
    ext_in_data = 16'hC0DE; ext_in_ready = 1;
    #1 chk("R6 one-cycle stall", {15'b0, stall}, 16'd1);
    @(negedge clk);
    req_valid = 0; ext_in_ready = 0;
    #1 chk("R6 stall drops fast", {15'b0, stall}, 16'd0);
    mdl[11] = 16'hC0DE;
    @(negedge clk);
    ld(10'd11, "R6 fast input written");

    // R7 ready with no pending input
    ext_in_data = 16'h1111; ext_in_ready = 1;
    idle(); idle();
    ext_in_ready = 0;
    ld(10'd9, "R7 stray ready ignored");
    ld(10'd11, "R7 stray ready ignored");

    // R8 reset keeps RAM, clears output state
    st(10'd20, 16'h5678, 4'd4, "R8");
    req_valid = 1; req_write = 1; req_reg = 0; req_addr = 10'd20;
    push(3, 16'd1, "R8 ready before reset");
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 10'h200 | 10'd21;
    @(negedge clk);
    rst_n = 0; req_valid = 0;
    @(negedge clk);
    rst_n = 1;
    chk("R8 out ready cleared", {15'b0, ext_out_ready}, 16'd0);
    chk("R8 out data cleared", ext_out_data, 16'd0);
    chk("R8 wait cleared", {15'b0, stall}, 16'd0);
    ld(10'd20, "R8 ram kept");
    ld(10'd5, "R8 ram kept");
    idle(); idle();
    done = 1;
    finish_run();
  end
endmodule